// File: doc/BRIEF.md
# Codec Control Serial Write Engine

This block turns parallel register-write requests into frames on a three-wire, write-only serial link that configures two codec devices. A host offers a chip index, a 5-bit register address and an 8-bit value on a valid/ready handshake. The engine builds a 16-bit word and shifts it out, most significant bit first. It uses one active-low select per device, a serial clock and a serial data line.

Every step on the link is followed by the same settle interval. The interval is a parameter counted in system clocks. The default gives about 100 µs at 125 MHz, and the bench sets a short value. While the link is idle, both selects, the clock and the data line are all held high. A transfer runs in this order: a quiet preamble, the select falls, 16 bit slots, then all lines return high, followed by a final quiet interval. After that interval the engine takes the next request.

Top module: `codec_ser_writer`

## Requirements
- R1: Each frame holds 16 bits and is sent MSB first. Bits 15:14 are the fixed device code 2'b10, bit 13 is a constant 1, bits 12:8 are the register address and bits 7:0 are the data.
- R2: Chip index 0 drives `cs_n[0]` low. Chip indices 1, 2 and 3 drive `cs_n[1]` low. The other select stays high for the whole frame.
- R3: While reset is asserted, and whenever neither select is low, `sclk` and `sdata` are high and `req_ready` is high in idle.
- R4: When a request is accepted, all link lines stay high for exactly DELAY_CYC clocks before the chosen select falls.
- R5: Each bit slot has three steps of DELAY_CYC clocks each: clock low, then data driven, then clock high. The clock is therefore low for 2·DELAY_CYC clocks before each rising edge. `sdata` never changes while `sclk` is high inside a frame.
- R6: After the 16th rising edge, the select, clock and data all go high in the same cycle. `req_ready` stays low for exactly 51·DELAY_CYC clocks after acceptance.
- R7: A request whose chip index is above 3 is consumed in one cycle. It causes no link activity and `req_ready` stays high.
- R8: A request presented while the engine is busy is held off and not dropped. It is accepted once `req_ready` returns, and its frame follows the current one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Engine can accept a request |
| req_chip | input | IDX_W | Target chip index |
| req_addr | input | 5 | Codec register address |
| req_data | input | 8 | Register value |
| cs_n | output | 2 | Active-low device selects |
| sclk | output | 1 | Serial clock, idles high |
| sdata | output | 1 | Serial data, idles high |

## Verification
The hardest case to reach from the ports is a request arriving while a frame is still on the wire. The engine must hold that request off and must not merge or drop it. The stimulus covers this by raising valid for the next request as soon as the previous one has been accepted, both in directed pairs and throughout the random stream. A passive monitor rebuilds every frame from the rising edges of the link clock. It then compares each frame, the select it used and its step timing against a queue of expected words. Out-of-range chip indices are mixed into the random stream so that rejected requests land between transfers.

// File: rtl/codec_wr_pkg.sv
package codec_wr_pkg;

    localparam int FRAME_W = 16;
    localparam int ADDR_W  = 5;
    localparam int DATA_W  = 8;

    localparam logic [1:0] DEV_CODE = 2'b10;
    localparam logic       WR_FLAG  = 1'b1;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_PRE,
        PH_SEL,
        PH_CLO,
        PH_DAT,
        PH_CHI,
        PH_END
    } phase_t;

    typedef struct packed {
        logic [1:0] cs_n;
        logic       sclk;
        logic       sdat;
    } link_t;

    localparam link_t LINK_REST = '{cs_n: 2'b11, sclk: 1'b1, sdat: 1'b1};

    function automatic logic [FRAME_W-1:0] pack_frame(
        input logic [ADDR_W-1:0] addr,
        input logic [DATA_W-1:0] data
    );
        return {DEV_CODE, WR_FLAG, addr, data};
    endfunction

    function automatic logic [1:0] select_for(input logic upper);
        return upper ? 2'b01 : 2'b10;
    endfunction

endpackage

// File: rtl/codec_step_timer.sv
module codec_step_timer #(
    parameter int DELAY_CYC = 12500
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic done
);
    localparam int CNT_W = (DELAY_CYC > 1) ? $clog2(DELAY_CYC) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DELAY_CYC - 1);

    logic [CNT_W-1:0] cnt;

    assign done = run && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || !run || done) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/codec_frame_shifter.sv
module codec_frame_shifter
    import codec_wr_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [FRAME_W-1:0] word,
    input  logic               shift,
    output logic               msb,
    output logic               last
);
    localparam int BIT_W = $clog2(FRAME_W);
    localparam logic [BIT_W-1:0] FINAL = BIT_W'(FRAME_W - 1);

    logic [FRAME_W-1:0] sreg;
    logic [BIT_W-1:0]   bidx;

    assign msb  = sreg[FRAME_W-1];
    assign last = (bidx == FINAL);

    always_ff @(posedge clk) begin
        if (rst) begin
            sreg <= '1;
            bidx <= '0;
        end else if (load) begin
            sreg <= word;
            bidx <= '0;
        end else if (shift) begin
            sreg <= {sreg[FRAME_W-2:0], 1'b1};
            bidx <= bidx + 1'b1;
        end
    end

endmodule

// File: rtl/codec_link_seq.sv
module codec_link_seq
    import codec_wr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       upper,
    input  logic       tick,
    input  logic       last_bit,
    input  logic       cur_bit,
    output logic       idle,
    output logic       load_en,
    output logic       shift_en,
    output logic [1:0] cs_n,
    output logic       sclk,
    output logic       sdat
);
    phase_t     phase, phase_nxt;
    link_t      link, link_nxt;
    logic [1:0] pick;

    assign idle    = (phase == PH_IDLE);
    assign load_en = idle && start;
    assign cs_n    = link.cs_n;
    assign sclk    = link.sclk;
    assign sdat    = link.sdat;

    always_comb begin
        phase_nxt = phase;
        link_nxt  = link;
        shift_en  = 1'b0;
        unique case (phase)
            PH_IDLE: begin
                link_nxt = LINK_REST;
                if (start) phase_nxt = PH_PRE;
            end
            PH_PRE: if (tick) begin
                phase_nxt     = PH_SEL;
                link_nxt.cs_n = pick;
            end
            PH_SEL: if (tick) begin
                phase_nxt     = PH_CLO;
                link_nxt.sclk = 1'b0;
            end
            PH_CLO: if (tick) begin
                phase_nxt     = PH_DAT;
                link_nxt.sdat = cur_bit;
            end
            PH_DAT: if (tick) begin
                phase_nxt     = PH_CHI;
                link_nxt.sclk = 1'b1;
            end
            PH_CHI: if (tick) begin
                if (last_bit) begin
                    phase_nxt = PH_END;
                    link_nxt  = LINK_REST;
                end else begin
                    phase_nxt     = PH_CLO;
                    link_nxt.sclk = 1'b0;
                    shift_en      = 1'b1;
                end
            end
            PH_END: if (tick) phase_nxt = PH_IDLE;
            default: begin
                phase_nxt = PH_IDLE;
                link_nxt  = LINK_REST;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            link  <= LINK_REST;
            pick  <= 2'b11;
        end else begin
            phase <= phase_nxt;
            link  <= link_nxt;
            if (load_en) pick <= select_for(upper);
        end
    end

    // R2: at most one device selected at a time
    assert_one_select_R2: assert property (@(posedge clk) disable iff (rst)
        $countones(~cs_n) <= 1);

    // R3: with no select active the clock and data rest high
    assert_rest_high_R3: assert property (@(posedge clk) disable iff (rst)
        (&cs_n) |-> (sclk && sdat));

    // R5: data is settled before the receiver samples on the rising clock
    assert_data_settled_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(sclk) |-> $stable(sdat));

    // R6: release of the select coincides with clock and data high
    assert_release_together_R6: assert property (@(posedge clk) disable iff (rst)
        ($rose(cs_n[0]) || $rose(cs_n[1])) |-> (sclk && sdat && (&cs_n)));

endmodule

// File: rtl/codec_ser_writer.sv
module codec_ser_writer
    import codec_wr_pkg::*;
#(
    parameter int DELAY_CYC = 12500,
    parameter int IDX_W     = 3,
    parameter int MAX_CHIP  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [IDX_W-1:0]  req_chip,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    output logic [1:0]        cs_n,
    output logic              sclk,
    output logic              sdata
);
    localparam logic [IDX_W-1:0] CHIP_LIMIT = IDX_W'(MAX_CHIP);

    logic fire, chip_ok, start, upper;
    logic idle, tick, load_en, shift_en, cur_bit, last_bit;

    assign req_ready = idle;
    assign fire      = req_valid && req_ready;
    assign chip_ok   = (req_chip <= CHIP_LIMIT);
    assign start     = fire && chip_ok;
    assign upper     = (req_chip != '0);

    codec_step_timer #(.DELAY_CYC(DELAY_CYC)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .run  (!idle),
        .done (tick)
    );

    codec_frame_shifter u_shift (
        .clk   (clk),
        .rst   (rst),
        .load  (load_en),
        .word  (pack_frame(req_addr, req_data)),
        .shift (shift_en),
        .msb   (cur_bit),
        .last  (last_bit)
    );

    codec_link_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .upper    (upper),
        .tick     (tick),
        .last_bit (last_bit),
        .cur_bit  (cur_bit),
        .idle     (idle),
        .load_en  (load_en),
        .shift_en (shift_en),
        .cs_n     (cs_n),
        .sclk     (sclk),
        .sdat     (sdata)
    );

    // R7: an out-of-range chip index leaves the engine idle and the link quiet
    assert_reject_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        (fire && !chip_ok) |=> (req_ready && (&cs_n) && sclk && sdata));

    // R8: an accepted request blocks further acceptance
    assert_hold_off_R8: assert property (@(posedge clk) disable iff (rst)
        (fire && chip_ok) |=> !req_ready);

endmodule

// File: tb/codec_ser_writer_tb.sv
module codec_ser_writer_tb;
    localparam int D = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic [2:0] req_chip = '0;
    logic [4:0] req_addr = '0;
    logic [7:0] req_data = '0;
    logic [1:0] cs_n;
    logic       sclk, sdata;

    int unsigned checks = 0, errors = 0;
    int unsigned cyc = 0;
    int unsigned accept_cyc = 0;
    logic [16:0] exp_q[$];

    always #4 clk = ~clk;

    codec_ser_writer #(.DELAY_CYC(D), .IDX_W(3), .MAX_CHIP(3)) u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_chip(req_chip), .req_addr(req_addr), .req_data(req_data),
        .cs_n(cs_n), .sclk(sclk), .sdata(sdata)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_frame(input logic [4:0] a, input logic [7:0] d);
        return {2'b10, 1'b1, a, d};
    endfunction

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            check(1'b0, "watchdog", int'(cyc), 150000);
            finish_run();
        end
    end

    // passive link monitor, sampled on the falling clock edge
    logic [1:0]  prev_cs = 2'b11;
    logic        prev_sclk = 1'b1, prev_sdat = 1'b1;
    logic [15:0] cap;
    logic        cap_upper;
    int unsigned nbits, low_cnt, busy_len = 0;

    always @(negedge clk) begin
        if (!rst) begin
            if (prev_cs == 2'b11 && cs_n != 2'b11) begin
                cap = '0; nbits = 0; low_cnt = 0;
                cap_upper = (cs_n == 2'b01);
                check(cyc - accept_cyc == D, "R4 select fall delay", int'(cyc - accept_cyc), D);
            end
            if (cs_n != 2'b11) begin
                if (prev_cs != 2'b11 && cs_n != prev_cs)
                    check(1'b0, "R2 select switched mid-frame", cs_n, prev_cs);
                if (sclk && !prev_sclk) begin
                    cap = {cap[14:0], sdata};
                    nbits++;
                    check(low_cnt == 2 * D, "R5 clock low width", low_cnt, 2 * D);
                    low_cnt = 0;
                end
                if (!sclk) low_cnt++;
                if (sclk && prev_sclk && sdata != prev_sdat)
                    check(1'b0, "R5 data moved while clock high", sdata, prev_sdat);
            end
            if (prev_cs != 2'b11 && cs_n == 2'b11) begin
                check(sclk && sdata, "R6 lines high together", {sclk, sdata}, 3);
                check(nbits == 16, "R1 bit count", nbits, 16);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R7 unexpected frame", cap, 0);
                end else begin
                    logic [16:0] e;
                    e = exp_q.pop_front();
                    check(cap == e[15:0], "R1 frame word", cap, e[15:0]);
                    check(cap_upper == e[16], "R2 select choice", cap_upper, e[16]);
                end
            end
            if (!req_ready) busy_len++;
            else if (busy_len != 0) begin
                check(busy_len == 51 * D, "R6 busy length", busy_len, 51 * D);
                busy_len = 0;
            end
        end
        prev_cs = cs_n; prev_sclk = sclk; prev_sdat = sdata;
    end

    // called on a falling edge; returns on the falling edge after acceptance
    task automatic send(input int idx, input logic [4:0] a, input logic [7:0] d);
        bit acc;
        req_valid = 1'b1;
        req_chip  = 3'(idx);
        req_addr  = a;
        req_data  = d;
        do begin
            acc = req_ready;
            @(negedge clk);
        end while (!acc);
        req_valid  = 1'b0;
        accept_cyc = cyc;
        if (idx <= 3) exp_q.push_back({idx != 0, exp_frame(a, d)});
    endtask

    task automatic wait_idle();
        while (!(req_ready && exp_q.size() == 0)) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic send_bad(input int idx);
        send(idx, 5'h0A, 8'h3C);
        check(req_ready == 1'b1, "R7 ready after reject", req_ready, 1);
        for (int k = 0; k < 10; k++) begin
            check(cs_n == 2'b11 && sclk && sdata, "R7 link quiet after reject",
                  {cs_n, sclk, sdata}, 4'hF);
            @(negedge clk);
        end
    endtask

    initial begin
        int unsigned seed;
        seed = $urandom(32'd7741);
        repeat (3) @(negedge clk);
        check(cs_n == 2'b11 && sclk && sdata, "R3 reset link state", {cs_n, sclk, sdata}, 4'hF);
        check(req_ready == 1'b1, "R3 ready in reset", req_ready, 1);
        rst = 1'b0;
        @(negedge clk);
        check(cs_n == 2'b11 && sclk && sdata, "R3 idle link state", {cs_n, sclk, sdata}, 4'hF);

        // directed: each select, extreme fields
        send(0, 5'h1F, 8'h00); wait_idle();
        send(1, 5'h00, 8'hFF); wait_idle();
        send(3, 5'h15, 8'hA5); wait_idle();
        send(2, 5'h0A, 8'h5A); wait_idle();
        // directed: rejected indices
        send_bad(4);
        send_bad(7);
        // directed: back-to-back, second held off while busy (R8)
        send(0, 5'h03, 8'h81);
        send(1, 5'h1C, 8'h7E);
        send(0, 5'h11, 8'h01);
        wait_idle();
        check(exp_q.size() == 0, "R8 all held requests delivered", exp_q.size(), 0);

        // random stream with back-to-back issue
        for (int n = 0; n < 30; n++) begin
            int idx;
            idx = int'($urandom_range(0, 7));
            if (idx > 3) send_bad(idx);
            else send(idx, 5'($urandom), 8'($urandom));
        end
        wait_idle();
        check(exp_q.size() == 0, "R8 random frames all seen", exp_q.size(), 0);
        check(cs_n == 2'b11 && sclk && sdata, "R3 final idle", {cs_n, sclk, sdata}, 4'hF);
        finish_run();
    end

endmodule